// File: doc/BRIEF.md
# Multichannel Gated Frequency Meter

The block measures the frequency of several unrelated input clocks against one shared gate interval. The gate is produced in the system clock domain. One build setting divides the system clock down to one pulse every `SYS_HZ` cycles. The other setting takes an external once-per-second pulse. Each gate event travels into every channel's own clock domain through a separate toggle synchronizer. Inside its domain, each channel keeps a free-running edge counter. On each synchronized gate, the channel moves that count into a held register and starts counting again from zero.

A channel-select input picks one channel's held count and its valid flag for the shared output. If the gate period is one second, the held count is that channel's frequency in hertz, less one edge. The held count changes only once per gate. System-side logic can therefore read it at any time between gates and get a whole value. The channel count must be at least two; any smaller value stops elaboration with an error.

Top module: `mc_freq_meter`

## Requirements
- R1: With `INT_TIMEBASE`=1 the gate comes from the internal divider and `pps_in` has no effect. With `INT_TIMEBASE`=0 the gate is `pps_in` registered once on `clk_sys`, and no channel latches until a pulse arrives.
- R2: The internal divider counts `clk_sys` cycles from 0 to `SYS_HZ`-1, then wraps to 0. It gives a one-cycle gate pulse on each wrap, so the gate period is `SYS_HZ` system cycles.
- R3: Let one gate interval last T and a channel clock period be P. The held count for that interval lies in the window from floor(T/P)-2 to ceil(T/P).
- R4: Each channel receives every accepted gate through its own synchronizer in its own clock domain. After the first accepted gate, every channel's valid flag is 1.
- R5: A channel clock edge that sees the synchronized gate does three things. It copies the running count into the held register, clears the running count and sets the channel's valid flag.
- R6: Every other channel clock edge adds one to the running count.
- R7: `rst_n` low clears all running counts, held registers, valid flags and the internal divider. While reset is held, `freq_out` is 0 and `freq_vld` is 0.
- R8: `ch_sel` is ceil(log2(`NCH`)) bits wide. The value k drives channel k's held register onto `freq_out` and its valid flag onto `freq_vld`.
- R9: Between two synchronized gates, a channel's held register and valid flag do not change.
- R10: The running count wraps modulo 2^`CNT_W`, so the held count is the true edge count modulo 2^`CNT_W`.
- R11: A gate is accepted only while every channel's synchronizer reports ready. A gate pulse that arrives while any channel is still busy is dropped, not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; the gate is formed here |
| rst_n | input | 1 | Asynchronous reset, active low, for all domains |
| ch_clk | input | NCH | One clock to be measured per channel |
| pps_in | input | 1 | External single-cycle gate pulse (used when INT_TIMEBASE=0) |
| ch_sel | input | SEL_W | Index of the channel shown on the output |
| freq_out | output | CNT_W | Held count of the selected channel |
| freq_vld | output | 1 | Valid flag of the selected channel |

## Verification
Four channel clocks with unrelated periods of 14, 22, 34 and 46 ns run against a 2000 ns gate. A count window that holds for all four shows that each domain latches on its own synchronized gate. A missing clear or a wrong increment would move one of them out of its window. A narrow 6-bit instance separates true modulo wrap from saturation. Reads repeated inside one gate period confirm the held value does not tear. Random select values and random toggling of the unused pulse pin show that the mux follows `ch_sel` and that the internal mode ignores the pin. With the external gate, a second pulse sent 120 ns after the first is dropped. A design that accepted it would produce a 14 ns channel count about 8 below the window.

// File: rtl/mc_freq_meter.sv
module mc_freq_meter #(
  parameter bit          INT_TIMEBASE = 1'b1,
  parameter int unsigned SYS_HZ       = 125_000_000,
  parameter int unsigned NCH          = 4,
  parameter int unsigned CNT_W        = 32,
  localparam int unsigned SEL_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk_sys,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ch_clk,
  input  logic             pps_in,
  input  logic [SEL_W-1:0] ch_sel,
  output logic [CNT_W-1:0] freq_out,
  output logic             freq_vld
);
  localparam int unsigned TB_W = (SYS_HZ > 1) ? $clog2(SYS_HZ) : 1;

  if (NCH < 2) begin : g_bad_nch
    $error("mc_freq_meter: NCH must be at least 2");
  end

  logic [TB_W-1:0]            tb_cnt;
  logic                       gate_req;
  logic                       src_tgl;
  logic [NCH-1:0]             rdy;
  logic                       rdy_all;
  logic                       gate_fire;
  logic [NCH-1:0]             gate_p;
  logic [NCH-1:0]             vld;
  logic [NCH-1:0][CNT_W-1:0]  cnt;
  logic [NCH-1:0][CNT_W-1:0]  frq;

  if (INT_TIMEBASE) begin : g_int
    logic unused_pps;
    assign unused_pps = pps_in;
    always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
        tb_cnt   <= '0;
        gate_req <= 1'b0;
      end else if (tb_cnt == TB_W'(SYS_HZ - 1)) begin
        tb_cnt   <= '0;
        gate_req <= 1'b1;
      end else begin
        tb_cnt   <= tb_cnt + 1'b1;
        gate_req <= 1'b0;
      end
    end
  end else begin : g_ext
    assign tb_cnt = '0;
    always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) gate_req <= 1'b0;
      else        gate_req <= pps_in;
    end
  end

  assign rdy_all   = &rdy;
  assign gate_fire = gate_req & rdy_all;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n)         src_tgl <= 1'b0;
    else if (gate_fire) src_tgl <= ~src_tgl;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic             sy1, sy2, sy3;
    logic             ak1, ak2;
    logic [CNT_W-1:0] run, held;
    logic             hv;
    logic             hit;

    always_ff @(posedge ch_clk[i] or negedge rst_n) begin
      if (!rst_n) {sy1, sy2, sy3} <= 3'b000;
      else        {sy1, sy2, sy3} <= {src_tgl, sy1, sy2};
    end

    assign hit = sy2 ^ sy3;

    always_ff @(posedge ch_clk[i] or negedge rst_n) begin
      if (!rst_n) begin
        run  <= '0;
        held <= '0;
        hv   <= 1'b0;
      end else if (hit) begin
        held <= run;
        run  <= '0;
        hv   <= 1'b1;
      end else begin
        run  <= run + 1'b1;
      end
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) {ak1, ak2} <= 2'b00;
      else        {ak1, ak2} <= {sy3, ak1};
    end

    assign rdy[i]    = (ak2 == src_tgl);
    assign gate_p[i] = hit;
    assign cnt[i]    = run;
    assign frq[i]    = held;
    assign vld[i]    = hv;
  end

  always_comb begin
    freq_out = '0;
    freq_vld = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      if (ch_sel == SEL_W'(k)) begin
        freq_out = frq[k];
        freq_vld = vld[k];
      end
    end
  end
endmodule

// File: rtl/mc_freq_meter_chk.sv
module mc_freq_meter_chk #(
  parameter bit          INT_TIMEBASE = 1'b1,
  parameter int unsigned SYS_HZ       = 125_000_000,
  parameter int unsigned NCH          = 4,
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned TB_W         = 27
) (
  input logic                      clk_sys,
  input logic                      rst_n,
  input logic [NCH-1:0]            ch_clk,
  input logic                      gate_req,
  input logic                      src_tgl,
  input logic                      rdy_all,
  input logic [TB_W-1:0]           tb_cnt,
  input logic [NCH-1:0]            gate_p,
  input logic [NCH-1:0]            vld,
  input logic [NCH-1:0][CNT_W-1:0] cnt,
  input logic [NCH-1:0][CNT_W-1:0] frq,
  input logic [CNT_W-1:0]          freq_out,
  input logic                      freq_vld
);
  if (INT_TIMEBASE) begin : g_int_chk
    AST_TB_BOUND: assert property (@(posedge clk_sys) disable iff (!rst_n) 32'(tb_cnt) < SYS_HZ); // R2
    AST_GATE_AT_WRAP: assert property (@(posedge clk_sys) disable iff (!rst_n) gate_req |-> tb_cnt == '0); // R2
    AST_GATE_ONE_CYCLE: assert property (@(posedge clk_sys) disable iff (!rst_n) gate_req |=> !gate_req); // R2
  end

  AST_TOGGLE_READY: assert property (@(posedge clk_sys) disable iff (!rst_n) !$stable(src_tgl) |-> $past(rdy_all)); // R11

  always @(posedge clk_sys) begin
    if (!rst_n) begin
      AST_RESET_OUT: assert (freq_out == '0 && !freq_vld); // R7
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch_chk
    AST_LATCH_CLEAR: assert property (@(posedge ch_clk[g]) disable iff (!rst_n) gate_p[g] |=> (cnt[g] == '0 && vld[g] && frq[g] == $past(cnt[g]))); // R5
    AST_COUNT_STEP: assert property (@(posedge ch_clk[g]) disable iff (!rst_n) !gate_p[g] |=> cnt[g] == $past(cnt[g]) + {{(CNT_W-1){1'b0}}, 1'b1}); // R6
    AST_HOLD_STABLE: assert property (@(posedge ch_clk[g]) disable iff (!rst_n) !gate_p[g] |=> ($stable(frq[g]) && $stable(vld[g]))); // R9
  end
endmodule

bind mc_freq_meter mc_freq_meter_chk #(
  .INT_TIMEBASE(INT_TIMEBASE),
  .SYS_HZ(SYS_HZ),
  .NCH(NCH),
  .CNT_W(CNT_W),
  .TB_W(TB_W)
) u_chk (
  .clk_sys(clk_sys),
  .rst_n(rst_n),
  .ch_clk(ch_clk),
  .gate_req(gate_req),
  .src_tgl(src_tgl),
  .rdy_all(rdy_all),
  .tb_cnt(tb_cnt),
  .gate_p(gate_p),
  .vld(vld),
  .cnt(cnt),
  .frq(frq),
  .freq_out(freq_out),
  .freq_vld(freq_vld)
);

// File: tb/sim_mc_freq_meter.sv
`timescale 1ns/1ps
module sim_mc_freq_meter;
  localparam int NCH   = 4;
  localparam int GATE  = 200;
  localparam int T_NS  = GATE * 10;
  localparam int SEL_W = 2;

  logic clk_sys = 1'b0;
  logic rst_n   = 1'b0;
  logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
  logic [NCH-1:0] ch_clk;
  logic pps_r = 1'b0;
  logic pps_x = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [31:0] f0, f2;
  logic [5:0]  f1;
  logic v0, v1, v2;
  int n_chk = 0;
  int n_fail = 0;
  int per [NCH] = '{14, 22, 34, 46};

  assign ch_clk = {c3, c2, c1, c0};

  always #5 clk_sys = ~clk_sys;
  initial forever #7  c0 = ~c0;
  initial forever #11 c1 = ~c1;
  initial forever #17 c2 = ~c2;
  initial forever #23 c3 = ~c3;

  mc_freq_meter #(.INT_TIMEBASE(1'b1), .SYS_HZ(GATE), .NCH(NCH), .CNT_W(32)) u0 (
    .clk_sys(clk_sys), .rst_n(rst_n), .ch_clk(ch_clk), .pps_in(pps_r),
    .ch_sel(sel), .freq_out(f0), .freq_vld(v0));

  mc_freq_meter #(.INT_TIMEBASE(1'b1), .SYS_HZ(GATE), .NCH(NCH), .CNT_W(6)) u1 (
    .clk_sys(clk_sys), .rst_n(rst_n), .ch_clk(ch_clk), .pps_in(pps_r),
    .ch_sel(sel), .freq_out(f1), .freq_vld(v1));

  mc_freq_meter #(.INT_TIMEBASE(1'b0), .SYS_HZ(GATE), .NCH(NCH), .CNT_W(32)) u2 (
    .clk_sys(clk_sys), .rst_n(rst_n), .ch_clk(ch_clk), .pps_in(pps_x),
    .ch_sel(sel), .freq_out(f2), .freq_vld(v2));

  function automatic int lo_of(input int p);
    return T_NS / p - 2;
  endfunction

  function automatic int hi_of(input int p);
    return (T_NS + p - 1) / p;
  endfunction

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_sys);
    @(negedge clk_sys);
  endtask

  task automatic pick(input int k);
    sel = SEL_W'(k);
    #1;
  endtask

  task automatic pulse_x();
    pps_x = 1'b1;
    cyc(1);
    pps_x = 1'b0;
  endtask

  task automatic chk_window(input string req, input logic [31:0] got, input int k);
    chk(req, got >= 32'(lo_of(per[k])) && got <= 32'(hi_of(per[k])), got, lo_of(per[k]));
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    #(200_000 * 10);
    chk("watchdog", 1'b0, 0, 1);
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    cyc(3);
    // R7: reset state on every channel
    for (int k = 0; k < NCH; k++) begin
      pick(k);
      chk("R7 reset freq u0", f0 == 0, f0, 0);
      chk("R7 reset vld u0", v0 == 0, v0, 0);
      chk("R7 reset vld u2", v2 == 0, v2, 0);
    end
    cyc(7);
    rst_n = 1'b1;

    cyc(GATE * 7 / 2);
    // R3/R4/R5 internal gate, R10 wrap on 6-bit instance, R1 external idle
    for (int k = 0; k < NCH; k++) begin
      pick(k);
      chk("R4 valid after gate", v0 == 1, v0, 1);
      chk_window("R3 count window", f0, k);
      chk("R10 wrap", 6'(f1 - 6'(lo_of(per[k]))) <= 6'(hi_of(per[k]) - lo_of(per[k])),
          f1, 6'(lo_of(per[k])));
      chk("R1 external idle no valid", v2 == 0, v2, 0);
    end

    // R9: held value stable inside one gate period
    begin
      logic [31:0] first;
      pick(0);
      first = f0;
      for (int r = 0; r < 6; r++) begin
        cyc(10);
        chk("R9 held stable", f0 == first, f0, first);
      end
    end

    // R8 / R1: random select with pps toggling on internal instances
    for (int it = 0; it < 24; it++) begin
      int k;
      k = int'($urandom % NCH);
      pps_r = 1'($urandom);
      cyc(1 + int'($urandom % 150));
      pick(k);
      chk_window("R8 R1 select random", f0, k);
      chk("R8 valid selected", v0 == 1, v0, 1);
    end
    pps_r = 1'b0;

    // R1 external gate: two pulses one gate period apart
    pulse_x();
    cyc(GATE - 1);
    pulse_x();
    cyc(GATE / 2);
    for (int k = 0; k < NCH; k++) begin
      pick(k);
      chk("R1 external valid", v2 == 1, v2, 1);
      chk_window("R1 R3 external window", f2, k);
    end

    // R11: second pulse while busy is dropped
    pulse_x();
    cyc(11);
    pulse_x();
    cyc(GATE - 13);
    pulse_x();
    cyc(GATE / 2);
    for (int k = 0; k < NCH; k++) begin
      pick(k);
      chk_window("R11 busy pulse dropped", f2, k);
    end

    // R7: reset in mid run, including the divider
    rst_n = 1'b0;
    #2;
    for (int k = 0; k < NCH; k++) begin
      pick(k);
      chk("R7 midrun freq u0", f0 == 0, f0, 0);
      chk("R7 midrun freq u2", f2 == 0, f2, 0);
    end
    cyc(5);
    rst_n = 1'b1;
    cyc(50);
    pick(1);
    chk("R7 divider restarted", v0 == 0, v0, 0);
    cyc(GATE);
    chk("R2 first gate after restart", v0 == 1, v0, 1);

    report();
    $finish;
  end
endmodule